// File: doc/BRIEF.md
# Register Bank Checksum Checker

This block protects a bank of configuration registers against silent corruption. A calculate command makes it read every register of the bank once, fold the values into a 14-bit signature and keep that signature. A later check command repeats the same scan and compares the fresh signature with the kept one. Any difference latches an error flag that stays set until it is cleared from outside.

The bank itself sits outside the block. The checker reaches it through a simple read port: it drives an address with a read enable, and the bank returns the addressed word on the following cycle. It visits one register per cycle in ascending order. A busy output covers the whole scan, and a single-cycle done pulse marks its end. The signature folds each register in with XOR after rotating it left by its own index, so a word that has moved to another slot changes the result.

Top module: `cfg_checksum_guard`

## Requirements
- R1: After a calculate command, `sum_value` holds S = XOR over i = 0..15 of rotl14(reg[i], i mod 14), where rotl14 rotates a 14-bit word left. The new value is visible in the cycle in which `done` is high.
- R2: Each accepted command raises `rd_en` for exactly 16 consecutive cycles, with `rd_addr` running 0, 1, ..., 15. The word for an address is taken from `rd_data` one cycle after that address is driven.
- R3: A check command recomputes S and compares it with the stored value. On a mismatch, `par_err` is 1 in the `done` cycle. On a match, `par_err` is left as it was.
- R4: The stored value is 0 after reset. A check issued before any calculate compares against 0.
- R5: A calculate command never changes `par_err`, whatever the bank holds.
- R6: Once set, `par_err` stays 1 until `err_clr` is sampled high at a clock edge. A matching check does not clear it. If a mismatch and `err_clr` meet at the same edge, the flag ends up set.
- R7: `busy` rises in the cycle after a command is accepted and stays high for 17 cycles. `done` is high for exactly one cycle, the first cycle after `busy` falls.
- R8: A command is accepted only while `busy` is low. A command seen while `busy` is high is ignored and changes neither `sum_value` nor `par_err`. If calculate and check arrive together, the calculate is executed.
- R9: While reset is asserted and after it is released, `busy`, `done`, `par_err` and `rd_en` are 0 and `sum_value` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_calc | input | 1 | Calculate and store the signature |
| cmd_check | input | 1 | Recalculate and compare against the stored signature |
| err_clr | input | 1 | Clears the sticky error flag |
| rd_en | output | 1 | Read request to the register bank |
| rd_addr | output | 4 | Register index being read |
| rd_data | input | 14 | Word returned by the bank one cycle after the request |
| busy | output | 1 | A scan is in progress |
| done | output | 1 | One-cycle pulse when a scan ends |
| par_err | output | 1 | Sticky signature mismatch flag |
| sum_value | output | 14 | Stored signature |

## Verification
The accepting edge is counted as edge 0. The read enable comes up right after it, the last word arrives after edge 16, and `done`, `sum_value` and `par_err` settle after edge 17. Every result is therefore due 17 edges after the accepting edge. The bench drives and samples at falling edges and counts the falling edges between the command and `done`. It expects `done` on the 18th falling edge after the command is driven, and it reads the signature and the flag only in that cycle or later. The sweep covers every single-bit flip of every register. Since the signature is linear, each flip must raise the flag, and the bench compares each stored signature with its own rotate-and-XOR model.

// File: rtl/ckg_pkg.sv
package ckg_pkg;
  typedef enum logic {
    OP_CALC  = 1'b0,
    OP_CHECK = 1'b1
  } ckg_op_e;
endpackage

// File: rtl/ckg_scan_seq.sv
module ckg_scan_seq #(
  parameter int NUM_REGS = 16,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             rd_en,
  output logic [IDX_W-1:0] rd_addr,
  output logic             beat_vld,
  output logic [IDX_W-1:0] beat_idx,
  output logic             beat_last,
  output logic             active
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

  logic             issuing_q;
  logic [IDX_W-1:0] addr_q;
  logic             vld_q;
  logic [IDX_W-1:0] idx_q;
  logic             last_q;
  logic             issue_last_w;

  assign issue_last_w = issuing_q && (addr_q == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issuing_q <= 1'b0;
      addr_q    <= '0;
    end else if (start) begin
      issuing_q <= 1'b1;
      addr_q    <= '0;
    end else if (issue_last_w) begin
      issuing_q <= 1'b0;
      addr_q    <= '0;
    end else if (issuing_q) begin
      addr_q    <= addr_q + 1'b1;
    end
  end

  // read data lags the address by one cycle; track index and last flag alongside
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      idx_q  <= '0;
      last_q <= 1'b0;
    end else begin
      vld_q  <= issuing_q;
      idx_q  <= addr_q;
      last_q <= issue_last_w;
    end
  end

  assign rd_en     = issuing_q;
  assign rd_addr   = addr_q;
  assign beat_vld  = vld_q;
  assign beat_idx  = idx_q;
  assign beat_last = vld_q && last_q;
  assign active    = issuing_q || vld_q;
endmodule

// File: rtl/ckg_accum.sv
module ckg_accum #(
  parameter int DATA_W   = 14,
  parameter int NUM_REGS = 16,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              beat_vld,
  input  logic [IDX_W-1:0]  beat_idx,
  input  logic [DATA_W-1:0] beat_data,
  output logic [DATA_W-1:0] sum_final
);
  function automatic logic [DATA_W-1:0] rotl(input logic [DATA_W-1:0] v,
                                             input logic [IDX_W-1:0]  idx);
    int amt;
    logic [2*DATA_W-1:0] dbl;
    amt = int'(idx) % DATA_W;
    dbl = {v, v} << amt;
    return dbl[2*DATA_W-1:DATA_W];
  endfunction

  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] term_w;

  assign term_w    = beat_vld ? rotl(beat_data, beat_idx) : '0;
  assign sum_final = acc_q ^ term_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        acc_q <= '0;
    else if (clear)    acc_q <= '0;
    else if (beat_vld) acc_q <= sum_final;
  end
endmodule

// File: rtl/ckg_result.sv
module ckg_result
  import ckg_pkg::*;
#(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fin,
  input  ckg_op_e           op,
  input  logic [DATA_W-1:0] sum_final,
  input  logic              err_clr,
  output logic [DATA_W-1:0] sum_value,
  output logic              par_err,
  output logic              done,
  output logic              store_w,
  output logic              mismatch_w
);
  logic [DATA_W-1:0] sum_q;
  logic              err_q;
  logic              done_q;

  assign store_w    = fin && (op == OP_CALC);
  assign mismatch_w = fin && (op == OP_CHECK) && (sum_final != sum_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sum_q <= '0;
    else if (store_w) sum_q <= sum_final;
  end

  // a mismatch outranks a clear arriving at the same edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          err_q <= 1'b0;
    else if (mismatch_w) err_q <= 1'b1;
    else if (err_clr)    err_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= fin;
  end

  assign sum_value = sum_q;
  assign par_err   = err_q;
  assign done      = done_q;
endmodule

// File: rtl/cfg_checksum_guard.sv
module cfg_checksum_guard
  import ckg_pkg::*;
#(
  parameter int DATA_W   = 14,
  parameter int NUM_REGS = 16,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_calc,
  input  logic              cmd_check,
  input  logic              err_clr,
  output logic              rd_en,
  output logic [IDX_W-1:0]  rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              done,
  output logic              par_err,
  output logic [DATA_W-1:0] sum_value
);
  logic             accept_w;
  logic             beat_vld_w;
  logic [IDX_W-1:0] beat_idx_w;
  logic             beat_last_w;
  logic             active_w;
  logic [DATA_W-1:0] sum_final_w;
  logic             store_w;
  logic             mismatch_w;
  logic             is_check_w;
  ckg_op_e          op_q;

  // calculate wins when both commands arrive together
  assign accept_w   = !active_w && (cmd_calc || cmd_check);
  assign is_check_w = (op_q == OP_CHECK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        op_q <= OP_CALC;
    else if (accept_w) op_q <= cmd_calc ? OP_CALC : OP_CHECK;
  end

  ckg_scan_seq #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept_w),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .beat_vld  (beat_vld_w),
    .beat_idx  (beat_idx_w),
    .beat_last (beat_last_w),
    .active    (active_w)
  );

  ckg_accum #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (accept_w),
    .beat_vld  (beat_vld_w),
    .beat_idx  (beat_idx_w),
    .beat_data (rd_data),
    .sum_final (sum_final_w)
  );

  ckg_result #(.DATA_W(DATA_W)) u_res (
    .clk        (clk),
    .rst_n      (rst_n),
    .fin        (beat_last_w),
    .op         (op_q),
    .sum_final  (sum_final_w),
    .err_clr    (err_clr),
    .sum_value  (sum_value),
    .par_err    (par_err),
    .done       (done),
    .store_w    (store_w),
    .mismatch_w (mismatch_w)
  );

  assign busy = active_w;
endmodule

// File: rtl/ckg_checker.sv
module ckg_checker #(
  parameter int DATA_W = 14,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_calc,
  input logic              cmd_check,
  input logic              err_clr,
  input logic              busy,
  input logic              done,
  input logic              par_err,
  input logic              rd_en,
  input logic [IDX_W-1:0]  rd_addr,
  input logic [DATA_W-1:0] sum_value,
  input logic              is_check,
  input logic              store_w
);
  // R2
  rd_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + 1'b1));

  // R2
  rd_addr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_en) |-> (rd_addr == '0));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_calc || cmd_check));

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err && !err_clr) |=> par_err);

  // R3
  err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(par_err) |-> (done && is_check));

  // R5
  calc_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !is_check) |-> !$rose(par_err));

  // R1
  sum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !store_w |=> $stable(sum_value));
endmodule

bind cfg_checksum_guard ckg_checker #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_calc  (cmd_calc),
  .cmd_check (cmd_check),
  .err_clr   (err_clr),
  .busy      (busy),
  .done      (done),
  .par_err   (par_err),
  .rd_en     (rd_en),
  .rd_addr   (rd_addr),
  .sum_value (sum_value),
  .is_check  (is_check_w),
  .store_w   (store_w)
);

// File: tb/cfg_checksum_guard_test.sv
`timescale 1ns/1ps
module cfg_checksum_guard_test;
  localparam int W   = 14;
  localparam int N   = 16;
  localparam int LAT = N + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_calc = 1'b0;
  logic          cmd_check = 1'b0;
  logic          err_clr = 1'b0;
  logic          rd_en;
  logic [3:0]    rd_addr;
  logic [W-1:0]  rd_data;
  logic          busy, done, par_err;
  logic [W-1:0]  sum_value;

  logic [W-1:0]  mem [N];
  int            n_chk = 0;
  int            n_fail = 0;
  int            exp_addr = 0;
  int            addr_bad = 0;
  int            rd_cnt = 0;
  bit            finished = 0;

  always #2 clk = ~clk;

  cfg_checksum_guard uut (
    .clk(clk), .rst_n(rst_n), .cmd_calc(cmd_calc), .cmd_check(cmd_check),
    .err_clr(err_clr), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .done(done), .par_err(par_err), .sum_value(sum_value)
  );

  always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

  always @(negedge clk) if (rst_n && rd_en) begin
    if (int'(rd_addr) != exp_addr) addr_bad++;
    exp_addr++;
    rd_cnt++;
  end

  function automatic logic [W-1:0] model_sum();
    logic [W-1:0] s = '0;
    for (int i = 0; i < N; i++) begin
      int sh = W - (i % W);
      logic [2*W-1:0] d = {mem[i], mem[i]} >> sh;
      s ^= d[W-1:0];
    end
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic run_op(input bit c, input bit k, output int lat);
    exp_addr = 0; rd_cnt = 0; addr_bad = 0;
    @(negedge clk); cmd_calc = c; cmd_check = k;
    @(negedge clk); cmd_calc = 0; cmd_check = 0; lat = 1;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
  endtask

  task automatic fill(input int p);
    for (int i = 0; i < N; i++) mem[i] = W'((p * 5003 + i * 1237 + (p ^ i) * 77) ^ (i << p % 5));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int lat;
    logic [W-1:0] s, saved;
    for (int i = 0; i < N; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!busy && !done && !par_err && !rd_en && sum_value == 0, "R9 reset",
        {busy, done, par_err, rd_en}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(sum_value == 0 && !busy, "R9 after release", sum_value, 0);

    // R4 check before calc, zero bank: matches stored zero
    run_op(0, 1, lat);
    chk(par_err == 0, "R4 zero bank check", par_err, 0);
    // R7 latency and R2 read count
    chk(lat == LAT, "R7 latency", lat, LAT);
    chk(rd_cnt == N && addr_bad == 0, "R2 read sequence", rd_cnt, N);

    // R4 check before calc with nonzero bank: mismatch against zero
    fill(3);
    run_op(0, 1, lat);
    chk(par_err == (model_sum() != 0), "R4 nonzero bank check", par_err, 1);
    // R6 sticky: clear
    @(negedge clk); err_clr = 1; @(negedge clk); err_clr = 0;
    chk(par_err == 0, "R6 clear", par_err, 0);

    // R1 / R3 sweep over patterns
    for (int p = 0; p < 24; p++) begin
      fill(p);
      run_op(1, 0, lat);
      s = model_sum();
      chk(sum_value == s, "R1 stored sum", sum_value, s);
      chk(lat == LAT && rd_cnt == N && addr_bad == 0, "R2 R7 calc scan", lat, LAT);
      run_op(0, 1, lat);
      chk(par_err == 0, "R3 match leaves flag", par_err, 0);
    end

    // R3 every single-bit flip is detected; R6 clear after each
    fill(11);
    run_op(1, 0, lat);
    for (int r = 0; r < N; r++) begin
      for (int b = 0; b < W; b++) begin
        mem[r][b] = ~mem[r][b];
        run_op(0, 1, lat);
        chk(par_err == 1, "R3 bit flip", par_err, 1);
        mem[r][b] = ~mem[r][b];
        @(negedge clk); err_clr = 1; @(negedge clk); err_clr = 0;
        chk(par_err == 0, "R6 clear after flip", par_err, 0);
      end
    end

    // R6 matching check does not clear a set flag
    mem[5] ^= 14'h0010;
    run_op(0, 1, lat);
    mem[5] ^= 14'h0010;
    run_op(0, 1, lat);
    chk(par_err == 1, "R6 match keeps flag", par_err, 1);

    // R5 calculate does not touch flag, whether set or clear
    fill(7);
    run_op(1, 0, lat);
    chk(par_err == 1, "R5 calc keeps set flag", par_err, 1);
    @(negedge clk); err_clr = 1; @(negedge clk); err_clr = 0;
    fill(8);
    run_op(1, 0, lat);
    chk(par_err == 0 && sum_value == model_sum(), "R5 calc leaves flag clear", par_err, 0);

    // R6 set beats clear at the same edge
    saved = sum_value;
    mem[0] ^= 14'h0001;
    err_clr = 1;
    run_op(0, 1, lat);
    chk(par_err == 1, "R6 set priority", par_err, 1);
    @(negedge clk);
    chk(par_err == 0, "R6 clear after priority", par_err, 1'b0);
    err_clr = 0;

    // R8 command while busy ignored
    exp_addr = 0; rd_cnt = 0;
    @(negedge clk); cmd_check = 1;
    @(negedge clk); cmd_check = 0;
    repeat (5) @(negedge clk);
    cmd_calc = 1; @(negedge clk); cmd_calc = 0;
    while (!done) @(negedge clk);
    chk(sum_value == saved, "R8 busy command ignored sum", sum_value, saved);
    @(negedge clk);
    chk(!busy && rd_cnt == N, "R8 no second scan", rd_cnt, N);
    @(negedge clk); err_clr = 1; @(negedge clk); err_clr = 0;

    // R8 both commands together: calculate wins
    run_op(1, 1, lat);
    chk(sum_value == model_sum() && par_err == 0, "R8 calc priority", sum_value, model_sum());

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule